// File: doc/BRIEF.md
# Smart Card Interface Interrupt Aggregator

This block gathers the event sources around an ISO 7816 smart card interface (the character UART, the card-presence and fault detector, the supply sequencing timer and the receive-length wait counter) into one 8-bit interrupt status word. It raises a single interrupt line toward the host. Each status bit has its own enable bit. The host learns the cause by reading the status word.

A host read clears most status bits. The receive-data bit is the exception. In normal operation it mirrors whether the receive FIFO holds data. In bypass operation, where firmware samples the card I/O line directly, it instead latches on a falling edge of that line.

The block also contains the wait-timeout counter. That counter advances on ETU ticks or on falling edges of the card clock. The card-event path uses an asynchronously set capture flop, so that insertion, removal or fault events are held while the main clock is stopped.

Top module: `sc_irq_hub`

## Requirements
- R1: After reset `status_o` is 8'h00 and `irq_o` is 0.
- R2: Status bit positions are fixed: bit0 receive data available, bit1 receive error, bit2 byte transmitted, bit3 transmit error, bit4 transmit FIFO level event, bit5 wait timeout, bit6 card event, bit7 supply timer. A single-cycle event pulse on a direct input sets its bit after the next rising clock edge.
- R3: A cycle with `host_rd_i` high clears bits 1 to 7 at the next edge. An event arriving in that same cycle leaves its bit set.
- R4: With `bypass_i` low, bit0 equals `rx_nempty_i` delayed by one edge, and `host_rd_i` does not clear it.
- R5: With `bypass_i` high, bit0 sets three edges after a falling edge on `card_io_i` and clears on a read. In this mode `rx_nempty_i` has no effect.
- R6: Bit2 sets on `byte_sent_i` or `chk_sent_i`. It does not set when `t0_mode_i`, `brk_det_en_i` and `brk_seen_i` are all high in the same cycle.
- R7: Bit3 sets on `tx_underrun_i`, or on `brk_seen_i` while `brk_det_en_i` is high. Bit1 sets on `rx_overrun_i` or `rx_parity_i`.
- R8: Bit4 sets when `tx_empty_i` or `tx_full_i` goes from 0 to 1. A flag that stays high does not set it again after a read.
- R9: A `wt_start_i` pulse captures `wt_limit_i` and zeroes the count. Each advance then adds one. Bit5 sets on the advance that makes the count reach the limit, where a limit of 0 acts as 1. The counter then stops until the next start.
- R10: With `wt_src_i`=0 the counter advances on each `etu_tick_i` cycle, and bit5 is visible two edges after the final tick. With `wt_src_i`=1 it advances on each falling edge of `card_clk_i`, and bit5 is visible four edges after the final falling edge.
- R11: A pulse on `card_evt_i` is held while the main clock is stopped. Bit6 becomes visible on the third rising clock edge after the clock runs again.
- R12: `irq_o` is the OR over the bits of `status_o & irq_en_i`. Masking changes `irq_o` only and leaves `status_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd_i | input | 1 | Host reads the status word this cycle |
| irq_en_i | input | 8 | Per-bit interrupt enable |
| status_o | output | 8 | Interrupt status word |
| irq_o | output | 1 | Interrupt request to the host |
| rx_nempty_i | input | 1 | Receive FIFO holds data |
| rx_overrun_i | input | 1 | Receive overrun pulse |
| rx_parity_i | input | 1 | Receive parity error pulse |
| bypass_i | input | 1 | Direct I/O line sampling mode |
| card_io_i | input | 1 | Card I/O line level |
| tx_empty_i | input | 1 | Transmit FIFO empty flag |
| tx_full_i | input | 1 | Transmit FIFO full flag |
| byte_sent_i | input | 1 | Data byte transmitted pulse |
| chk_sent_i | input | 1 | Block checksum byte transmitted pulse |
| t0_mode_i | input | 1 | Character protocol selected |
| brk_det_en_i | input | 1 | Break detection enabled |
| brk_seen_i | input | 1 | Break detected at end of byte |
| tx_underrun_i | input | 1 | Transmit underrun pulse |
| wt_start_i | input | 1 | Load limit and start wait counter |
| wt_limit_i | input | WT_W | Wait counter terminal value |
| wt_src_i | input | 1 | Advance source: 0 ETU tick, 1 card clock |
| etu_tick_i | input | 1 | ETU tick pulse |
| card_clk_i | input | 1 | Card clock level |
| supply_tmo_i | input | 1 | Supply timer expiry pulse |
| card_evt_i | input | 1 | Card presence change or fault pulse, asynchronous |

## Verification
Each result has its own fixed latency. Direct event pulses and the FIFO-level mirror appear after one edge. An ETU-driven timeout appears after two edges. A bypass falling edge on the I/O line appears after three edges, and a card-clock-driven timeout after four. A card event appears on the third edge after the clock resumes. The bench drives inputs just after a falling clock edge and samples at falling edges. For the delayed paths it checks that the bit is still clear one edge before it is due and set exactly at the due edge. The random phase compares the whole status word and the interrupt line against a bench model on every cycle.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;
   localparam int N_SRC      = 8;
   localparam int IDX_RXA    = 0;
   localparam int IDX_RXERR  = 1;
   localparam int IDX_TXSENT = 2;
   localparam int IDX_TXERR  = 3;
   localparam int IDX_TXLVL  = 4;
   localparam int IDX_WAIT   = 5;
   localparam int IDX_CARD   = 6;
   localparam int IDX_SUPPLY = 7;
   typedef logic [N_SRC-1:0] sc_stat_t;
endpackage

// File: rtl/sc_edge_sync.sv
module sc_edge_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_i,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sc_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;
   logic              prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[s] <= IDLE;
            else        sh[s] <= din_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[s] <= IDLE;
            else        sh[s] <= sh[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= sh[STAGES-1];
   end

   assign fall_o = prev_q & ~sh[STAGES-1];

   // R5, R10: a detected falling edge lasts one cycle only
   assert_fall_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/sc_wait_timer.sv
module sc_wait_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] limit_i,
   input  logic         adv_i,
   output logic         hit_o
);
   if (W < 2) begin : g_bad_width
      $error("sc_wait_timer: W must be at least 2");
   end

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q, lim_q, eff_lim, cnt_nxt;
   logic         run_q, hit_q;

   assign eff_lim = (lim_q == '0) ? ONE : lim_q;
   assign cnt_nxt = cnt_q + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
         run_q <= 1'b0;
         hit_q <= 1'b0;
      end else begin
         hit_q <= 1'b0;
         if (start_i) begin
            cnt_q <= '0;
            lim_q <= limit_i;
            run_q <= 1'b1;
         end else if (run_q && adv_i) begin
            cnt_q <= cnt_nxt;
            if (cnt_nxt >= eff_lim) begin
               run_q <= 1'b0;
               hit_q <= 1'b1;
            end
         end
      end
   end

   assign hit_o = hit_q;

   // R9: a running count never sits at or past its terminal value
   assert_wt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q < eff_lim));
   // R9: a terminal hit leaves the counter stopped
   assert_wt_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> !run_q);
endmodule

// File: rtl/sc_card_capture.sv
module sc_card_capture #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   output logic set_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sc_card_capture: STAGES must be at least 2");
   end

   logic              cap_q;
   logic [STAGES-1:0] sy;
   logic              seen_q;

   always_ff @(posedge clk or negedge rst_n or posedge evt_i) begin
      if (!rst_n)                cap_q <= 1'b0;
      else if (evt_i)            cap_q <= 1'b1;
      else if (sy[STAGES-1])     cap_q <= 1'b0;
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy[s] <= 1'b0;
            else        sy[s] <= cap_q;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy[s] <= 1'b0;
            else        sy[s] <= sy[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= sy[STAGES-1];
   end

   assign set_o = sy[STAGES-1] & ~seen_q;

   // R11: one captured event yields one set pulse
   assert_card_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_o |=> !set_o);
endmodule

// File: rtl/sc_irq_status.sv
module sc_irq_status
   import sc_irq_pkg::*;
#(
   parameter int NB = N_SRC
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_i,
   input  logic          bypass_i,
   input  logic          rxa_level_i,
   input  logic [NB-1:0] set_i,
   output logic [NB-1:0] stat_o
);
   if (NB != N_SRC) begin : g_bad_nb
      $error("sc_irq_status: NB must match the source count");
   end

   for (genvar i = 0; i < NB; i++) begin : g_bit
      logic bit_q;
      if (i == IDX_RXA) begin : g_rxa
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (bypass_i) bit_q <= (bit_q & ~rd_i) | set_i[i];
            else               bit_q <= rxa_level_i;
         end
         // R4: an empty FIFO clears the bit outside bypass mode
         assert_rxa_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!bypass_i && !rxa_level_i) |=> !bit_q);
         // R5: a bypass edge always lands in the bit
         assert_rxa_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (bypass_i && set_i[i]) |=> bit_q);
      end else begin : g_cor
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= (bit_q & ~rd_i) | set_i[i];
         end
         // R3: a read with no new event clears the bit
         assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && !set_i[i]) |=> !bit_q);
         // R3: an event is never lost, even beside a read
         assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> bit_q);
      end
      assign stat_o[i] = bit_q;
   end
endmodule

// File: rtl/sc_irq_hub.sv
module sc_irq_hub
   import sc_irq_pkg::*;
#(
   parameter int WT_W        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_rd_i,
   input  logic [N_SRC-1:0] irq_en_i,
   output logic [N_SRC-1:0] status_o,
   output logic            irq_o,
   input  logic            rx_nempty_i,
   input  logic            rx_overrun_i,
   input  logic            rx_parity_i,
   input  logic            bypass_i,
   input  logic            card_io_i,
   input  logic            tx_empty_i,
   input  logic            tx_full_i,
   input  logic            byte_sent_i,
   input  logic            chk_sent_i,
   input  logic            t0_mode_i,
   input  logic            brk_det_en_i,
   input  logic            brk_seen_i,
   input  logic            tx_underrun_i,
   input  logic            wt_start_i,
   input  logic [WT_W-1:0] wt_limit_i,
   input  logic            wt_src_i,
   input  logic            etu_tick_i,
   input  logic            card_clk_i,
   input  logic            supply_tmo_i,
   input  logic            card_evt_i
);
   logic     io_fall, cclk_fall, wt_adv, wt_hit, card_set;
   logic     emp_q, full_q, lvl_rise, sent_ok;
   sc_stat_t set_vec, stat;

   sc_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) i_io_edge (
      .clk(clk), .rst_n(rst_n), .din_i(card_io_i), .fall_o(io_fall));

   sc_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) i_cclk_edge (
      .clk(clk), .rst_n(rst_n), .din_i(card_clk_i), .fall_o(cclk_fall));

   assign wt_adv = wt_src_i ? cclk_fall : etu_tick_i;

   sc_wait_timer #(.W(WT_W)) i_wait (
      .clk(clk), .rst_n(rst_n), .start_i(wt_start_i), .limit_i(wt_limit_i),
      .adv_i(wt_adv), .hit_o(wt_hit));

   sc_card_capture #(.STAGES(SYNC_STAGES)) i_card (
      .clk(clk), .rst_n(rst_n), .evt_i(card_evt_i), .set_o(card_set));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         emp_q  <= 1'b0;
         full_q <= 1'b0;
      end else begin
         emp_q  <= tx_empty_i;
         full_q <= tx_full_i;
      end
   end

   assign lvl_rise = (tx_empty_i & ~emp_q) | (tx_full_i & ~full_q);
   assign sent_ok  = ~(t0_mode_i & brk_det_en_i & brk_seen_i);

   always_comb begin
      set_vec             = '0;
      set_vec[IDX_RXA]    = io_fall;
      set_vec[IDX_RXERR]  = rx_overrun_i | rx_parity_i;
      set_vec[IDX_TXSENT] = (byte_sent_i | chk_sent_i) & sent_ok;
      set_vec[IDX_TXERR]  = tx_underrun_i | (brk_seen_i & brk_det_en_i);
      set_vec[IDX_TXLVL]  = lvl_rise;
      set_vec[IDX_WAIT]   = wt_hit;
      set_vec[IDX_CARD]   = card_set;
      set_vec[IDX_SUPPLY] = supply_tmo_i;
   end

   sc_irq_status #(.NB(N_SRC)) i_status (
      .clk(clk), .rst_n(rst_n), .rd_i(host_rd_i), .bypass_i(bypass_i),
      .rxa_level_i(rx_nempty_i), .set_i(set_vec), .stat_o(stat));

   assign status_o = stat;
   assign irq_o    = |(stat & irq_en_i);

   // R12: with every source masked the line stays quiet
   assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_i == '0) |-> !irq_o);
   // R6: a break at the end of a character byte blocks the sent flag
   assert_sent_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (t0_mode_i && brk_det_en_i && brk_seen_i && !status_o[IDX_TXSENT]) |=>
      !status_o[IDX_TXSENT]);
endmodule

// File: tb/test_sc_irq_hub.sv
`timescale 1ns/1ps
module test_sc_irq_hub;
   localparam int WT_W = 16;

   logic clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
   logic host_rd_i = 0, rx_nempty_i = 0, rx_overrun_i = 0, rx_parity_i = 0;
   logic bypass_i = 0, card_io_i = 1, tx_empty_i = 0, tx_full_i = 0;
   logic byte_sent_i = 0, chk_sent_i = 0, t0_mode_i = 0, brk_det_en_i = 0;
   logic brk_seen_i = 0, tx_underrun_i = 0, wt_start_i = 0, wt_src_i = 0;
   logic etu_tick_i = 0, card_clk_i = 1, supply_tmo_i = 0, card_evt_i = 0;
   logic [7:0] irq_en_i = 8'hFF;
   logic [WT_W-1:0] wt_limit_i = '0;
   logic [7:0] status_o;
   logic irq_o;

   int total = 0, bad = 0;

   always #5 if (clk_run) clk = ~clk;

   sc_irq_hub #(.WT_W(WT_W), .SYNC_STAGES(2)) i_sc_irq_hub (
      .clk(clk), .rst_n(rst_n), .host_rd_i(host_rd_i), .irq_en_i(irq_en_i),
      .status_o(status_o), .irq_o(irq_o), .rx_nempty_i(rx_nempty_i),
      .rx_overrun_i(rx_overrun_i), .rx_parity_i(rx_parity_i),
      .bypass_i(bypass_i), .card_io_i(card_io_i), .tx_empty_i(tx_empty_i),
      .tx_full_i(tx_full_i), .byte_sent_i(byte_sent_i), .chk_sent_i(chk_sent_i),
      .t0_mode_i(t0_mode_i), .brk_det_en_i(brk_det_en_i), .brk_seen_i(brk_seen_i),
      .tx_underrun_i(tx_underrun_i), .wt_start_i(wt_start_i),
      .wt_limit_i(wt_limit_i), .wt_src_i(wt_src_i), .etu_tick_i(etu_tick_i),
      .card_clk_i(card_clk_i), .supply_tmo_i(supply_tmo_i),
      .card_evt_i(card_evt_i));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_pulses();
      host_rd_i = 0; rx_overrun_i = 0; rx_parity_i = 0; byte_sent_i = 0;
      chk_sent_i = 0; brk_seen_i = 0; tx_underrun_i = 0; wt_start_i = 0;
      etu_tick_i = 0; supply_tmo_i = 0;
   endtask

   task automatic host_read();
      host_rd_i = 1; step(); host_rd_i = 0;
   endtask

   task automatic etu_tick();
      etu_tick_i = 1; step(); etu_tick_i = 0; step();
   endtask

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // next status word from the requirements (non-bypass, no timer or card events)
   function automatic logic [7:0] model(input logic [7:0] cur, input logic rd,
         input logic nempty, input logic rxe, input logic sent, input logic txe,
         input logic lvl, input logic sup);
      logic [7:0] n;
      n    = rd ? 8'h00 : cur;
      n[0] = nempty;
      n[1] = n[1] | rxe;
      n[2] = n[2] | sent;
      n[3] = n[3] | txe;
      n[4] = n[4] | lvl;
      n[7] = n[7] | sup;
      return n;
   endfunction

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_up();
   end

   initial begin
      logic [7:0] exp_st;
      logic pe, pf;
      void'($urandom(32'd4711));

      // R1 reset state
      step(2);
      chk("R1 status in reset", status_o, 8'h00);
      chk("R1 irq in reset", irq_o, 1'b0);
      rst_n = 1;
      step();
      chk("R1 status after reset", status_o, 8'h00);

      // R2 / R12 single source and masking
      rx_overrun_i = 1; step(); rx_overrun_i = 0;
      chk("R2 overrun sets bit1", status_o, 8'h02);
      chk("R12 irq enabled", irq_o, 1'b1);
      irq_en_i = 8'h00; #1;
      chk("R12 irq masked", irq_o, 1'b0);
      chk("R12 mask keeps status", status_o, 8'h02);
      irq_en_i = 8'hFD; #1;
      chk("R12 other bits enabled only", irq_o, 1'b0);
      irq_en_i = 8'h02; #1;
      chk("R12 own bit enabled", irq_o, 1'b1);
      irq_en_i = 8'hFF;

      // R3 read clear and same-cycle set
      step();
      host_read();
      chk("R3 read clears", status_o, 8'h00);
      host_rd_i = 1; supply_tmo_i = 1; rx_parity_i = 1; step(); clear_pulses();
      chk("R3 set beside read survives", status_o, 8'h82);
      host_read();
      chk("R3 cleared again", status_o, 8'h00);

      // R4 receive level mirror
      rx_nempty_i = 1; step();
      chk("R4 follows fifo", status_o, 8'h01);
      host_read();
      chk("R4 read does not clear", status_o, 8'h01);
      rx_nempty_i = 0; step();
      chk("R4 fifo empty clears", status_o, 8'h00);

      // R6 / R7 transmit flags
      t0_mode_i = 1; brk_det_en_i = 1; brk_seen_i = 1; byte_sent_i = 1; step(); clear_pulses();
      chk("R6 break blocks sent in T0", status_o, 8'h08);
      host_read();
      t0_mode_i = 0; brk_seen_i = 1; byte_sent_i = 1; step(); clear_pulses();
      chk("R6 block mode sends despite break", status_o, 8'h0C);
      host_read();
      chk_sent_i = 1; step(); clear_pulses();
      chk("R6 checksum byte sets sent", status_o, 8'h04);
      host_read();
      t0_mode_i = 1; brk_det_en_i = 0; brk_seen_i = 1; byte_sent_i = 1; step(); clear_pulses();
      chk("R7 R6 break ignored when detection off", status_o, 8'h04);
      host_read(); t0_mode_i = 0;
      tx_underrun_i = 1; step(); clear_pulses();
      chk("R7 underrun sets bit3", status_o, 8'h08);
      host_read();

      // R8 transmit level event
      tx_empty_i = 1; step();
      chk("R8 empty rise", status_o, 8'h10);
      host_read(); step(2);
      chk("R8 steady empty no reset", status_o, 8'h00);
      tx_full_i = 1; step();
      chk("R8 full rise", status_o, 8'h10);
      host_read(); tx_empty_i = 0; tx_full_i = 0; step();

      // random phase against the model
      exp_st = 8'h00; pe = 0; pf = 0;
      chk("R3 random start", status_o, exp_st);
      for (int i = 0; i < 600; i++) begin
         logic rxe, snt, txe, lvl;
         host_rd_i     = (($urandom % 4) == 0);
         rx_nempty_i   = (($urandom % 3) == 0);
         rx_overrun_i  = (($urandom % 9) == 0);
         rx_parity_i   = (($urandom % 9) == 0);
         byte_sent_i   = (($urandom % 7) == 0);
         chk_sent_i    = (($urandom % 11) == 0);
         t0_mode_i     = $urandom % 2;
         brk_det_en_i  = $urandom % 2;
         brk_seen_i    = (($urandom % 5) == 0);
         tx_underrun_i = (($urandom % 13) == 0);
         supply_tmo_i  = (($urandom % 10) == 0);
         if (($urandom % 6) == 0) tx_empty_i = ~tx_empty_i;
         if (($urandom % 6) == 0) tx_full_i = ~tx_full_i;
         irq_en_i      = 8'($urandom);
         rxe = rx_overrun_i | rx_parity_i;
         snt = (byte_sent_i | chk_sent_i) & ~(t0_mode_i & brk_det_en_i & brk_seen_i);
         txe = tx_underrun_i | (brk_seen_i & brk_det_en_i);
         lvl = (tx_empty_i & ~pe) | (tx_full_i & ~pf);
         exp_st = model(exp_st, host_rd_i, rx_nempty_i, rxe, snt, txe, lvl, supply_tmo_i);
         pe = tx_empty_i; pf = tx_full_i;
         step();
         chk("R2 R3 R4 R6 R7 R8 random status", status_o, exp_st);
         chk("R12 random irq", irq_o, |(exp_st & irq_en_i));
      end
      clear_pulses();
      t0_mode_i = 0; brk_det_en_i = 0; rx_nempty_i = 0; tx_empty_i = 0; tx_full_i = 0;
      irq_en_i = 8'hFF;
      step(); host_read();
      chk("R3 cleared after random", status_o, 8'h00);

      // R9 / R10 wait timer on ETU ticks
      wt_src_i = 0; wt_limit_i = 5;
      wt_start_i = 1; step(); wt_start_i = 0;
      repeat (4) etu_tick();
      step(2);
      chk("R9 no timeout before limit", status_o, 8'h00);
      etu_tick_i = 1; step(); etu_tick_i = 0;
      chk("R10 etu timeout not yet", status_o, 8'h00);
      step();
      chk("R10 etu timeout two edges", status_o, 8'h20);
      host_read();
      repeat (6) etu_tick();
      chk("R9 stopped after hit", status_o, 8'h00);
      wt_limit_i = 0; wt_start_i = 1; step(); wt_start_i = 0;
      etu_tick_i = 1; step(); etu_tick_i = 0; step();
      chk("R9 limit zero acts as one", status_o, 8'h20);
      host_read();

      // R10 card clock source
      wt_src_i = 1; wt_limit_i = 3;
      wt_start_i = 1; step(); wt_start_i = 0;
      repeat (2) begin
         card_clk_i = 0; step(3); card_clk_i = 1; step(3);
      end
      step(4);
      chk("R10 two card clock edges no timeout", status_o, 8'h00);
      card_clk_i = 0; step(3);
      chk("R10 card clock timeout not yet", status_o, 8'h00);
      step();
      chk("R10 card clock timeout four edges", status_o, 8'h20);
      card_clk_i = 1; wt_src_i = 0; host_read();

      // R5 bypass edge
      bypass_i = 1; rx_nempty_i = 1; step(2);
      chk("R5 fifo level ignored in bypass", status_o, 8'h00);
      card_io_i = 0; step(2);
      chk("R5 io edge not yet", status_o, 8'h00);
      step();
      chk("R5 io edge sets bit0", status_o, 8'h01);
      card_io_i = 1; host_read(); step(2);
      chk("R5 read clears in bypass", status_o, 8'h00);
      bypass_i = 0; step();
      chk("R4 back to fifo mirror", status_o, 8'h01);
      rx_nempty_i = 0; step();

      // R11 card event with the clock stopped
      clk_run = 0;
      #20 card_evt_i = 1;
      #3  card_evt_i = 0;
      #20 clk_run = 1;
      step(2);
      chk("R11 card event not yet", status_o, 8'h00);
      step();
      chk("R11 card event held across stopped clock", status_o, 8'h40);
      chk("R12 card event raises irq", irq_o, 1'b1);
      host_read(); step(3);
      chk("R11 single card event", status_o, 8'h00);

      finish_up();
   end
endmodule